// File: doc/BRIEF.md
# Configuration IDSEL Hiding Unit

This block sits in the configuration space of a bridge that drives a secondary parallel bus. It holds a small hide register that software writes. During the address phase of a type-0 configuration cycle, it uses that register to gate the per-device IDSEL lines carried on the upper AD bits. When the hide flag of the addressed device is set, that device's IDSEL line is held low. The device then never sees itself selected and never claims the cycle. The requester ends with a master abort and concludes the slot is empty. The device is not switched off through its own registers.

The register lives in the configuration dword at byte offset 40h, in the low 16 bits. Only the four lowest bits are storage: one hide flag per device 0 to 3. Device n takes AD[16+n] as its IDSEL. Memory cycles, I/O cycles and data phases pass through unchanged, as do configuration cycles to devices 4 and above.

The AD gate is combinational, so a masked bit appears in the same cycle as its address phase. Register writes take effect on the next clock. Reads return their data one clock after the read strobe.

Top module: `idsel_mask_unit`

## Requirements
- R1: After reset all hide flags are 0: a read of dword index 10h returns 00000000h, and every address phase passes AD unchanged.
- R2: A write to dword index 10h with byte enable bit 0 set loads hide flag n from write data bit n (n = 0..3). A later read returns those flags in read data bits 3:0.
- R3: Read data bits 31:4 are always 0, whatever value was written to them.
- R4: A write to dword index 10h with byte enable bit 0 clear leaves all hide flags unchanged.
- R5: A write to any other dword index leaves the hide flags unchanged, and a read of any other dword index returns 0.
- R6: During a type-0 configuration address phase to device n (n < 4) whose hide flag is 1, ad_o bit 16+n is 0 and every other bit of ad_o equals ad_i.
- R7: During a type-0 configuration address phase to device n (n < 4) whose hide flag is 0, ad_o equals ad_i.
- R8: Outside a type-0 configuration address phase (data phases, memory or I/O cycles), ad_o equals ad_i for every hide setting.
- R9: Configuration cycles addressed to device numbers 4 and above pass AD unchanged.
- R10: rd_data_o updates on the clock edge that samples cfg_rd_i and holds its value otherwise. A read in the same cycle as a write returns the value from before the write.
- R11: A hide write affects gating starting with the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_rd_i | input | 1 | Configuration register read strobe |
| cfg_dword_i | input | 6 | Dword index of the configuration access (byte offset divided by 4) |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid from the clock after a read strobe |
| bus_addr_ph_i | input | 1 | Secondary bus is in an address phase |
| bus_cfg_t0_i | input | 1 | Current cycle is a type-0 configuration cycle |
| bus_dev_i | input | 5 | Target device number of the configuration cycle |
| ad_i | input | 32 | AD value from the bridge's bus driver |
| ad_o | output | 32 | AD value after IDSEL gating |

## Verification
The bench covers partial byte enables and writes to neighbouring dwords. A design that decodes byte enables loosely or matches the offset too widely would change the hide flags, and the readback would show it. It drives data phases, memory cycles and device numbers above 3 while flags are set. A gate that ignores the phase or the cycle type would clear AD bits there, and so would one that truncates the device number. It also changes a flag and then addresses that device in the next cycle, and reads in the same cycle as a write. These catch an off-by-one in write timing or read-during-write ordering. On every address phase, AD[16+n] must be low exactly when flag n is set. A gate wired to the wrong bit fails this check.

// File: rtl/idsel_mask_pkg.sv
package idsel_mask_pkg;
    // Defaults shared by the unit and its sub-blocks
    localparam int unsigned NUM_DEV_DEF    = 4;
    localparam int unsigned AD_W_DEF       = 32;
    localparam int unsigned IDSEL_LSB_DEF  = 16;
    localparam int unsigned DEV_W_DEF      = 5;
    localparam int unsigned CFG_DW_DEF     = 32;
    localparam int unsigned OFF_W_DEF      = 6;
    localparam int unsigned HIDE_DWORD_DEF = 16;  // byte offset 40h

    // Bit of the AD bus that serves as IDSEL for a given device
    function automatic int unsigned idsel_bit(input int unsigned lsb, input int unsigned dev);
        return lsb + dev;
    endfunction
endpackage

// File: rtl/idsel_hide_reg.sv
module idsel_hide_reg
    import idsel_mask_pkg::*;
#(
    parameter int unsigned NUM_DEV    = NUM_DEV_DEF,
    parameter int unsigned DW         = CFG_DW_DEF,
    parameter int unsigned OFF_W      = OFF_W_DEF,
    parameter int unsigned HIDE_DWORD = HIDE_DWORD_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [OFF_W-1:0]   dword_i,
    input  logic [DW/8-1:0]    be_i,
    input  logic [DW-1:0]      wdata_i,
    output logic [NUM_DEV-1:0] hide_o,
    output logic [DW-1:0]      rdata_o
);
    localparam int unsigned BE_W = DW / 8;

    typedef struct packed {
        logic [NUM_DEV-1:0] hide;
        logic [DW-1:0]      rdata;
    } hreg_t;

    hreg_t st_d, st_q;
    logic  hit;

    always_comb begin
        hit  = (dword_i == OFF_W'(HIDE_DWORD));
        st_d = st_q;
        // Each flag is written only when the byte lane holding it is enabled
        if (wr_i && hit) begin
            for (int i = 0; i < NUM_DEV; i++) begin
                if (be_i[i / 8]) begin
                    st_d.hide[i] = wdata_i[i];
                end
            end
        end
        // Read captures the flags as they stood before any same-cycle write
        if (rd_i) begin
            st_d.rdata = '0;
            if (hit) begin
                st_d.rdata[NUM_DEV-1:0] = st_q.hide;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hide_o  = st_q.hide;
    assign rdata_o = st_q.rdata;

    // Reserved write bits and upper lanes carry no storage
    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[DW-1:NUM_DEV], be_i[BE_W-1:0]};
endmodule

// File: rtl/idsel_gate.sv
module idsel_gate
    import idsel_mask_pkg::*;
#(
    parameter int unsigned NUM_DEV   = NUM_DEV_DEF,
    parameter int unsigned AD_W      = AD_W_DEF,
    parameter int unsigned IDSEL_LSB = IDSEL_LSB_DEF,
    parameter int unsigned DEV_W     = DEV_W_DEF
) (
    input  logic               addr_ph_i,
    input  logic               cfg_t0_i,
    input  logic [DEV_W-1:0]   dev_i,
    input  logic [NUM_DEV-1:0] hide_i,
    input  logic [AD_W-1:0]    ad_i,
    output logic [AD_W-1:0]    ad_o
);
    logic               cfg_addr;
    logic [NUM_DEV-1:0] kill;

    assign cfg_addr = addr_ph_i && cfg_t0_i;

    for (genvar n = 0; n < NUM_DEV; n++) begin : g_kill
        assign kill[n] = cfg_addr && (dev_i == DEV_W'(n)) && hide_i[n];
    end

    always_comb begin
        ad_o = ad_i;
        for (int n = 0; n < NUM_DEV; n++) begin
            if (kill[n]) begin
                ad_o[idsel_bit(IDSEL_LSB, n)] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/idsel_mask_unit.sv
module idsel_mask_unit
    import idsel_mask_pkg::*;
#(
    parameter int unsigned NUM_DEV    = NUM_DEV_DEF,
    parameter int unsigned AD_W       = AD_W_DEF,
    parameter int unsigned IDSEL_LSB  = IDSEL_LSB_DEF,
    parameter int unsigned DEV_W      = DEV_W_DEF,
    parameter int unsigned DW         = CFG_DW_DEF,
    parameter int unsigned OFF_W      = OFF_W_DEF,
    parameter int unsigned HIDE_DWORD = HIDE_DWORD_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic              cfg_rd_i,
    input  logic [OFF_W-1:0]  cfg_dword_i,
    input  logic [DW/8-1:0]   cfg_be_i,
    input  logic [DW-1:0]     cfg_wdata_i,
    output logic [DW-1:0]     rd_data_o,
    input  logic              bus_addr_ph_i,
    input  logic              bus_cfg_t0_i,
    input  logic [DEV_W-1:0]  bus_dev_i,
    input  logic [AD_W-1:0]   ad_i,
    output logic [AD_W-1:0]   ad_o
);
    logic [NUM_DEV-1:0] hide;

    idsel_hide_reg #(
        .NUM_DEV(NUM_DEV), .DW(DW), .OFF_W(OFF_W), .HIDE_DWORD(HIDE_DWORD)
    ) u_reg (
        .clk(clk), .rst_n(rst_n),
        .wr_i(cfg_wr_i), .rd_i(cfg_rd_i), .dword_i(cfg_dword_i),
        .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
        .hide_o(hide), .rdata_o(rd_data_o)
    );

    idsel_gate #(
        .NUM_DEV(NUM_DEV), .AD_W(AD_W), .IDSEL_LSB(IDSEL_LSB), .DEV_W(DEV_W)
    ) u_gate (
        .addr_ph_i(bus_addr_ph_i), .cfg_t0_i(bus_cfg_t0_i), .dev_i(bus_dev_i),
        .hide_i(hide), .ad_i(ad_i), .ad_o(ad_o)
    );
endmodule

// File: rtl/idsel_mask_chk.sv
module idsel_mask_chk #(
    parameter int unsigned NUM_DEV   = 4,
    parameter int unsigned AD_W      = 32,
    parameter int unsigned IDSEL_LSB = 16,
    parameter int unsigned DEV_W     = 5,
    parameter int unsigned DW        = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_rd_i,
    input logic [DW-1:0]    rd_data_o,
    input logic             bus_addr_ph_i,
    input logic             bus_cfg_t0_i,
    input logic [DEV_W-1:0] bus_dev_i,
    input logic [AD_W-1:0]  ad_i,
    input logic [AD_W-1:0]  ad_o
);
    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DW-1:NUM_DEV] == '0);

    // R8
    non_cfg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr_ph_i && bus_cfg_t0_i) |-> (ad_o == ad_i));

    // R9
    high_dev_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_dev_i) >= NUM_DEV) |-> (ad_o == ad_i));

    // R6
    only_target_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_ph_i && bus_cfg_t0_i && int'(bus_dev_i) < NUM_DEV) |->
        (((ad_o ^ ad_i) & ~(AD_W'(1) << (IDSEL_LSB + int'(bus_dev_i)))) == '0));

    // R6
    never_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_o & ~ad_i) == '0);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_i |=> $stable(rd_data_o));
endmodule

bind idsel_mask_unit idsel_mask_chk #(
    .NUM_DEV(NUM_DEV), .AD_W(AD_W), .IDSEL_LSB(IDSEL_LSB), .DEV_W(DEV_W), .DW(DW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_rd_i(cfg_rd_i), .rd_data_o(rd_data_o),
    .bus_addr_ph_i(bus_addr_ph_i), .bus_cfg_t0_i(bus_cfg_t0_i),
    .bus_dev_i(bus_dev_i), .ad_i(ad_i), .ad_o(ad_o)
);

// File: tb/idsel_mask_unit_tb.sv
module idsel_mask_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_i = 1'b0, cfg_rd_i = 1'b0;
    logic [5:0]  cfg_dword_i = '0;
    logic [3:0]  cfg_be_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] rd_data_o;
    logic        bus_addr_ph_i = 1'b0, bus_cfg_t0_i = 1'b0;
    logic [4:0]  bus_dev_i = '0;
    logic [31:0] ad_i = '0;
    logic [31:0] ad_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int unsigned m_hide = 0;
    int unsigned m_rd   = 0;

    always #5 clk = ~clk;

    idsel_mask_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_i(cfg_wr_i), .cfg_rd_i(cfg_rd_i), .cfg_dword_i(cfg_dword_i),
        .cfg_be_i(cfg_be_i), .cfg_wdata_i(cfg_wdata_i), .rd_data_o(rd_data_o),
        .bus_addr_ph_i(bus_addr_ph_i), .bus_cfg_t0_i(bus_cfg_t0_i),
        .bus_dev_i(bus_dev_i), .ad_i(ad_i), .ad_o(ad_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One bus cycle: check read data, drive, check AD, then advance the model
    task automatic cycle(input bit wr, input bit rd, input logic [5:0] dw,
                         input logic [3:0] be, input logic [31:0] wd,
                         input bit ap, input bit t0, input logic [4:0] dev,
                         input logic [31:0] ad, input string rtag);
        logic [31:0] exp_ad;
        string       atag;
        @(negedge clk);
        check(rtag, "read data", rd_data_o, m_rd);
        cfg_wr_i = wr; cfg_rd_i = rd; cfg_dword_i = dw; cfg_be_i = be;
        cfg_wdata_i = wd; bus_addr_ph_i = ap; bus_cfg_t0_i = t0;
        bus_dev_i = dev; ad_i = ad;
        #1;
        exp_ad = ad;
        if (!(ap && t0))           atag = "R8";
        else if (dev >= 5'd4)      atag = "R9";
        else if (m_hide[dev])      atag = "R6";
        else                       atag = "R7";
        if (ap && t0 && dev < 5'd4 && m_hide[dev]) exp_ad[16 + dev] = 1'b0;
        check(atag, "ad_o", ad_o, exp_ad);
        if (ap && t0 && dev < 5'd4)
            check(atag, "idsel bit", {31'd0, ad_o[16 + dev]},
                  {31'd0, ad[16 + dev] & ~m_hide[dev]});
        @(posedge clk);
        if (rd) m_rd = (dw == 6'h10) ? (m_hide & 32'hF) : 0;
        if (wr && dw == 6'h10 && be[0]) m_hide = wd & 32'hF;
    endtask

    task automatic idle(input string rtag);
        cycle(0, 0, 6'h00, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, rtag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cycle(0, 1, 6'h10, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, "R1");
        idle("R1");
        for (int d = 0; d < 4; d++)
            cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'(d), 32'hFFFF_FFFF, "R1");

        // R2, R3: load flags 0101 with reserved bits set, read back
        cycle(1, 0, 6'h10, 4'h1, 32'hFFFF_FFF5, 0, 0, 5'd0, 32'h0, "R2");
        cycle(0, 1, 6'h10, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, "R2");
        idle("R3");

        // R6, R7, R9: address phases to every device number with two patterns
        for (int d = 0; d < 8; d++) begin
            cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'(d), 32'hFFFF_FFFF, "R3");
            cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'(d), 32'h000F_0000, "R3");
        end
        cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'd31, 32'hFFFF_FFFF, "R9");

        // R8: data phase and memory cycle with flags set
        for (int d = 0; d < 4; d++) begin
            cycle(0, 0, 6'h00, 4'h0, 32'h0, 0, 1, 5'(d), 32'hFFFF_FFFF, "R8");
            cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 0, 5'(d), 32'hFFFF_FFFF, "R8");
        end

        // R4: lane 0 disabled
        cycle(1, 0, 6'h10, 4'h2, 32'h0000_000A, 0, 0, 5'd0, 32'h0, "R4");
        cycle(1, 0, 6'h10, 4'hE, 32'hFFFF_FFFA, 0, 0, 5'd0, 32'h0, "R4");
        cycle(0, 1, 6'h10, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, "R4");
        cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'd0, 32'hFFFF_FFFF, "R4");

        // R5: neighbouring dwords
        cycle(1, 0, 6'h11, 4'hF, 32'hFFFF_FFFF, 0, 0, 5'd0, 32'h0, "R5");
        cycle(1, 0, 6'h0F, 4'hF, 32'hFFFF_FFFF, 0, 0, 5'd0, 32'h0, "R5");
        cycle(0, 1, 6'h11, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, "R5");
        cycle(0, 1, 6'h10, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, "R5");
        idle("R5");

        // R11: new flags gate the very next address phase
        cycle(1, 0, 6'h10, 4'h1, 32'h0000_000A, 0, 0, 5'd0, 32'h0, "R11");
        cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'd1, 32'hFFFF_FFFF, "R11");
        cycle(0, 0, 6'h00, 4'h0, 32'h0, 1, 1, 5'd0, 32'hFFFF_FFFF, "R11");

        // R10: read during write returns old value, then holds across idles
        cycle(1, 1, 6'h10, 4'h1, 32'h0000_000F, 0, 0, 5'd0, 32'h0, "R10");
        idle("R10");
        idle("R10");
        cycle(0, 1, 6'h10, 4'h0, 32'h0, 0, 0, 5'd0, 32'h0, "R10");
        idle("R10");

        // Mixed traffic
        for (int i = 0; i < 400; i++) begin
            automatic logic [31:0] r  = $urandom;
            automatic bit          w  = (r[3:0] == 4'h0);
            automatic bit          rd = (r[7:4] == 4'h1);
            cycle(w, rd, (r[8] ? 6'h10 : 6'(r[13:9])), r[17:14], $urandom,
                  r[18] | r[19], r[20] | r[21], 5'(r[24:22]), $urandom, "R10");
        end
        idle("R10");

        finish_run();
    end
endmodule